// File: doc/BRIEF.md
# Priority Crossbar Pin Assigner

This block places a group of internal digital peripheral signals onto a bank of general-purpose port pins. The placement follows a fixed priority order. Software enables peripherals as groups through two small enable words. A per-pin skip mask takes a pin out of the crossbar's reach, and a per-pin mode bit makes the pin's output stage push-pull or open-drain. Each enabled signal takes the lowest-numbered pin that is neither skipped nor already taken. Signals that find no pin stay unconnected and raise an overflow flag.

Any pin that carries no peripheral behaves as GPIO and is driven from its port latch bit. For every pin the block produces a drive-enable and a drive value. For every peripheral signal it returns the level of the pin the signal sits on. The raw pin levels are always returned for reading, whatever the configuration. The assignment logic is combinational, and one register stage on every output makes all results appear one clock after the inputs that caused them.

Top module: `xbar_crossbar`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `pin_oe`, `pin_do`, `pin_rd` and `overflow` read 0 and `sig_in` reads all ones.
- R2: Every output reflects the inputs sampled at the previous rising clock edge. A change of configuration and a change of data at the same edge both appear together one cycle later.
- R3: The signal indices, from highest to lowest priority, are as follows:
  - 0: clock output (`grp_en_a[0]`)
  - 1–2: two-wire bus data and clock (`grp_en_a[1]`)
  - 3–4: serial transmit and receive (`grp_en_a[2]`)
  - 5–8: synchronous serial clock, data-in, data-out and select (`grp_en_a[3]`)
  - 9: comparator output (`grp_en_b[0]`)
  - 10 to 9+NUM_PCA: counter-array channels (`grp_en_b[1]`)
  - 10+NUM_PCA: timer 0 input (`grp_en_b[2]`)
  - 11+NUM_PCA: timer 1 input (`grp_en_b[3]`)
- R4: The enabled signals, taken in index order, occupy the unskipped pins in ascending pin order. The k-th enabled signal sits on the k-th unskipped pin.
- R5: A pin whose `pin_skip` bit is set never carries a peripheral signal and behaves as GPIO.
- R6: When more signals are enabled than pins are unskipped, the excess lowest-priority signals stay unconnected and `overflow` is 1. Otherwise `overflow` is 0.
- R7: In push-pull mode (`pin_od`=0), an assigned pin gets `pin_oe` from the signal's `sig_oe` and `pin_do` from its `sig_out`. A GPIO pin gets `pin_oe`=1 and `pin_do` from its `port_latch` bit.
- R8: In open-drain mode (`pin_od`=1), `pin_do` is 0. `pin_oe` is 1 only when the wanted value is 0, and for an assigned pin only when the signal's `sig_oe` is also 1.
- R9: `sig_in` of an assigned signal returns `pin_in` of its pin. An unconnected signal reads 1.
- R10: `pin_rd` returns `pin_in` for every pin, independent of enables, skips and modes.
- R11: With both enable words zero, every pin is GPIO and `overflow` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_en_a | input | 4 | Enable word A: clock out, two-wire bus, serial port, synchronous serial |
| grp_en_b | input | 4 | Enable word B: comparator, counter array, timer 0, timer 1 |
| pin_skip | input | NUM_PINS | Per-pin skip mask |
| pin_od | input | NUM_PINS | Per-pin open-drain mode |
| port_latch | input | NUM_PINS | GPIO output latch |
| pin_in | input | NUM_PINS | Pin levels from the pads |
| sig_out | input | NUM_SIG | Output value of each peripheral signal |
| sig_oe | input | NUM_SIG | Drive request of each peripheral signal |
| sig_in | output | NUM_SIG | Routed pin level for each peripheral signal |
| pin_oe | output | NUM_PINS | Per-pin drive enable |
| pin_do | output | NUM_PINS | Per-pin drive value |
| pin_rd | output | NUM_PINS | Raw pin level readback |
| overflow | output | 1 | More enabled signals than free pins |

## Verification
The function most likely to go wrong in a real system is a reconfiguration that lands in the same cycle as a change of pin and peripheral data. The new placement must then carry the new data, with no cycle that mixes the old routing and the new data. The bench provokes this by driving a fresh random enable set, skip mask, mode mask and data set at every edge, back to back. A reference model that scans pins one at a time checks each result one cycle later. Overflow falling together with open-drain pins is provoked in the same way, by skip masks that leave fewer pins free than there are enabled signals.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  localparam int GRP_CNT   = 8;
  localparam int FIXED_SIG = 12;

  // Group that owns signal s, given the number of counter-array channels.
  function automatic int sig_group(input int s, input int npca);
    if (s == 0)              return 0;
    else if (s < 3)          return 1;
    else if (s < 5)          return 2;
    else if (s < 9)          return 3;
    else if (s == 9)         return 4;
    else if (s < 10 + npca)  return 5;
    else if (s == 10 + npca) return 6;
    else                     return 7;
  endfunction

endpackage

// File: rtl/xbar_sig_enable.sv
module xbar_sig_enable #(
  parameter int NUM_PCA = 3,
  parameter int NUM_SIG = 15
) (
  input  logic [xbar_pkg::GRP_CNT-1:0] grp_en,
  output logic [NUM_SIG-1:0]           sig_en
);
  for (genvar s = 0; s < NUM_SIG; s++) begin : g_sig
    localparam int GRP = xbar_pkg::sig_group(s, NUM_PCA);
    assign sig_en[s] = grp_en[GRP];
  end
endmodule

// File: rtl/xbar_assign.sv
module xbar_assign #(
  parameter int NUM_PINS = 24,
  parameter int NUM_SIG  = 15,
  localparam int SW = $clog2(NUM_SIG),
  localparam int PW = $clog2(NUM_PINS),
  localparam int RW = $clog2(((NUM_PINS > NUM_SIG) ? NUM_PINS : NUM_SIG) + 1)
) (
  input  logic [NUM_SIG-1:0]            sig_en,
  input  logic [NUM_PINS-1:0]           pin_skip,
  output logic [NUM_PINS-1:0]           pin_hit,
  output logic [NUM_PINS-1:0][SW-1:0]   pin_sel,
  output logic [NUM_SIG-1:0]            sig_hit,
  output logic [NUM_SIG-1:0][PW-1:0]    sig_pin,
  output logic                          overflow
);
  logic [NUM_SIG-1:0][RW-1:0]  sig_rank;
  logic [NUM_PINS-1:0][RW-1:0] pin_rank;
  logic [RW-1:0]               n_en;
  logic [RW-1:0]               n_free;

  // Rank of each enabled signal among enabled signals.
  always_comb begin
    n_en = '0;
    for (int s = 0; s < NUM_SIG; s++) begin
      sig_rank[s] = n_en;
      n_en        = n_en + {{(RW-1){1'b0}}, sig_en[s]};
    end
  end

  // Rank of each unskipped pin among unskipped pins.
  always_comb begin
    n_free = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      pin_rank[p] = n_free;
      n_free      = n_free + {{(RW-1){1'b0}}, ~pin_skip[p]};
    end
  end

  // Matching ranks pair a signal with a pin.
  always_comb begin
    pin_hit = '0;
    pin_sel = '0;
    sig_hit = '0;
    sig_pin = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      for (int s = 0; s < NUM_SIG; s++) begin
        if (!pin_skip[p] && sig_en[s] && (pin_rank[p] == sig_rank[s])) begin
          pin_hit[p] = 1'b1;
          pin_sel[p] = SW'(s);
          sig_hit[s] = 1'b1;
          sig_pin[s] = PW'(p);
        end
      end
    end
  end

  assign overflow = (n_en > n_free);
endmodule

// File: rtl/xbar_pin_drive.sv
module xbar_pin_drive #(
  parameter int NUM_PINS = 24,
  parameter int NUM_SIG  = 15,
  localparam int SW = $clog2(NUM_SIG)
) (
  input  logic [NUM_PINS-1:0]         pin_hit,
  input  logic [NUM_PINS-1:0][SW-1:0] pin_sel,
  input  logic [NUM_PINS-1:0]         pin_od,
  input  logic [NUM_PINS-1:0]         port_latch,
  input  logic [NUM_SIG-1:0]          sig_out,
  input  logic [NUM_SIG-1:0]          sig_oe,
  output logic [NUM_PINS-1:0]         drv_oe,
  output logic [NUM_PINS-1:0]         drv_do
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic want_val;
    logic want_oe;
    assign want_val = pin_hit[p] ? sig_out[pin_sel[p]] : port_latch[p];
    assign want_oe  = pin_hit[p] ? sig_oe[pin_sel[p]]  : 1'b1;
    // Open-drain stages only ever pull low.
    assign drv_oe[p] = pin_od[p] ? (want_oe & ~want_val) : want_oe;
    assign drv_do[p] = pin_od[p] ? 1'b0 : want_val;
  end
endmodule

// File: rtl/xbar_in_route.sv
module xbar_in_route #(
  parameter int NUM_PINS = 24,
  parameter int NUM_SIG  = 15,
  localparam int PW = $clog2(NUM_PINS)
) (
  input  logic [NUM_SIG-1:0]          sig_hit,
  input  logic [NUM_SIG-1:0][PW-1:0]  sig_pin,
  input  logic [NUM_PINS-1:0]         pin_in,
  output logic [NUM_SIG-1:0]          route_in
);
  for (genvar s = 0; s < NUM_SIG; s++) begin : g_sig
    assign route_in[s] = sig_hit[s] ? pin_in[sig_pin[s]] : 1'b1;
  end
endmodule

// File: rtl/xbar_crossbar.sv
module xbar_crossbar #(
  parameter int NUM_PINS = 24,
  parameter int NUM_PCA  = 3,
  localparam int NUM_SIG = xbar_pkg::FIXED_SIG + NUM_PCA
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [3:0]          grp_en_a,
  input  logic [3:0]          grp_en_b,
  input  logic [NUM_PINS-1:0] pin_skip,
  input  logic [NUM_PINS-1:0] pin_od,
  input  logic [NUM_PINS-1:0] port_latch,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_SIG-1:0]  sig_out,
  input  logic [NUM_SIG-1:0]  sig_oe,
  output logic [NUM_SIG-1:0]  sig_in,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] pin_do,
  output logic [NUM_PINS-1:0] pin_rd,
  output logic                overflow
);
  localparam int SW = $clog2(NUM_SIG);
  localparam int PW = $clog2(NUM_PINS);

  logic [NUM_SIG-1:0]          sig_en;
  logic [NUM_PINS-1:0]         pin_hit;
  logic [NUM_PINS-1:0][SW-1:0] pin_sel;
  logic [NUM_SIG-1:0]          sig_hit;
  logic [NUM_SIG-1:0][PW-1:0]  sig_pin;
  logic                        ovf_c;
  logic [NUM_PINS-1:0]         drv_oe;
  logic [NUM_PINS-1:0]         drv_do;
  logic [NUM_SIG-1:0]          route_in;

  xbar_sig_enable #(.NUM_PCA(NUM_PCA), .NUM_SIG(NUM_SIG)) u_en (
    .grp_en ({grp_en_b, grp_en_a}),
    .sig_en (sig_en)
  );

  xbar_assign #(.NUM_PINS(NUM_PINS), .NUM_SIG(NUM_SIG)) u_assign (
    .sig_en   (sig_en),
    .pin_skip (pin_skip),
    .pin_hit  (pin_hit),
    .pin_sel  (pin_sel),
    .sig_hit  (sig_hit),
    .sig_pin  (sig_pin),
    .overflow (ovf_c)
  );

  xbar_pin_drive #(.NUM_PINS(NUM_PINS), .NUM_SIG(NUM_SIG)) u_drive (
    .pin_hit    (pin_hit),
    .pin_sel    (pin_sel),
    .pin_od     (pin_od),
    .port_latch (port_latch),
    .sig_out    (sig_out),
    .sig_oe     (sig_oe),
    .drv_oe     (drv_oe),
    .drv_do     (drv_do)
  );

  xbar_in_route #(.NUM_PINS(NUM_PINS), .NUM_SIG(NUM_SIG)) u_route (
    .sig_hit  (sig_hit),
    .sig_pin  (sig_pin),
    .pin_in   (pin_in),
    .route_in (route_in)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_oe   <= '0;
      pin_do   <= '0;
      pin_rd   <= '0;
      sig_in   <= '1;
      overflow <= 1'b0;
    end else begin
      pin_oe   <= drv_oe;
      pin_do   <= drv_do;
      pin_rd   <= pin_in;
      sig_in   <= route_in;
      overflow <= ovf_c;
    end
  end
endmodule

// File: rtl/xbar_crossbar_chk.sv
module xbar_crossbar_chk #(
  parameter int NUM_PINS = 24
) (
  input logic                clk,
  input logic                rst,
  input logic [3:0]          grp_en_a,
  input logic [3:0]          grp_en_b,
  input logic [NUM_PINS-1:0] pin_skip,
  input logic [NUM_PINS-1:0] pin_od,
  input logic [NUM_PINS-1:0] port_latch,
  input logic [NUM_PINS-1:0] pin_in,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NUM_PINS-1:0] pin_do,
  input logic [NUM_PINS-1:0] pin_rd,
  input logic                overflow
);
  // R10
  rd_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pin_rd == $past(pin_in));

  // R8
  od_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (pin_do & $past(pin_od)) == '0);

  // R11
  all_gpio_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(grp_en_a) == 4'd0 && $past(grp_en_b) == 4'd0)
    |-> (pin_oe == $past(~pin_od | ~port_latch)) && (pin_do == $past(port_latch & ~pin_od)));

  // R5
  skip_gpio_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((pin_do ^ $past(port_latch & ~pin_od)) & $past(pin_skip)) == '0);

  // R6
  full_skip_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(&pin_skip) && $past(|{grp_en_a, grp_en_b})) |-> overflow);

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past({grp_en_a, grp_en_b}) == 8'd0) |-> !overflow);
endmodule

bind xbar_crossbar xbar_crossbar_chk #(.NUM_PINS(NUM_PINS)) u_chk (.*);

// File: tb/xbar_crossbar_tb.sv
module xbar_crossbar_tb;
  localparam int NP   = 24;
  localparam int NPCA = 3;
  localparam int NS   = 12 + NPCA;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    grp_en_a = '0, grp_en_b = '0;
  logic [NP-1:0] pin_skip = '0, pin_od = '0, port_latch = '0, pin_in = '0;
  logic [NS-1:0] sig_out = '0, sig_oe = '0;
  logic [NS-1:0] sig_in;
  logic [NP-1:0] pin_oe, pin_do, pin_rd;
  logic          overflow;

  always #2 clk = ~clk;

  xbar_crossbar #(.NUM_PINS(NP), .NUM_PCA(NPCA)) u_dut (
    .clk(clk), .rst(rst), .grp_en_a(grp_en_a), .grp_en_b(grp_en_b),
    .pin_skip(pin_skip), .pin_od(pin_od), .port_latch(port_latch), .pin_in(pin_in),
    .sig_out(sig_out), .sig_oe(sig_oe), .sig_in(sig_in),
    .pin_oe(pin_oe), .pin_do(pin_do), .pin_rd(pin_rd), .overflow(overflow)
  );

  typedef struct {
    logic [NP-1:0] oe, dout, rd;
    logic [NS-1:0] sin;
    logic          ovf;
    string         req;
  } exp_t;

  exp_t q[$];
  int n_run  = 0;
  int n_fail = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Group enable bit index of each signal, per R3.
  function automatic int grp_of(input int s);
    if (s == 0) return 0;
    if (s <= 2) return 1;
    if (s <= 4) return 2;
    if (s <= 8) return 3;
    if (s == 9) return 4;
    if (s <= 9 + NPCA) return 5;
    if (s == 10 + NPCA) return 6;
    return 7;
  endfunction

  // Driver: applies one input set and queues the expected outputs (R2: next edge).
  task automatic drive(input logic [3:0] ea, input logic [3:0] eb,
                       input logic [NP-1:0] skip, input logic [NP-1:0] od,
                       input logic [NP-1:0] latch, input logic [NP-1:0] pins,
                       input logic [NS-1:0] so, input logic [NS-1:0] soe, input string req);
    exp_t e;
    int   pin_of[NS];
    int   p;
    logic [7:0] en;
    logic v, r;
    @(negedge clk);
    grp_en_a = ea; grp_en_b = eb; pin_skip = skip; pin_od = od;
    port_latch = latch; pin_in = pins; sig_out = so; sig_oe = soe;
    en = {eb, ea};
    e.ovf = 1'b0; p = 0;
    for (int s = 0; s < NS; s++) begin
      pin_of[s] = -1;
      if (en[grp_of(s)]) begin
        while (p < NP && skip[p]) p++;
        if (p < NP) begin pin_of[s] = p; p++; end
        else e.ovf = 1'b1;
      end
    end
    for (int k = 0; k < NP; k++) begin
      v = latch[k]; r = 1'b1;
      for (int s = 0; s < NS; s++)
        if (pin_of[s] == k) begin v = so[s]; r = soe[s]; end
      e.oe[k]   = od[k] ? (r & ~v) : r;
      e.dout[k] = od[k] ? 1'b0 : v;
    end
    for (int s = 0; s < NS; s++)
      e.sin[s] = (pin_of[s] >= 0) ? pins[pin_of[s]] : 1'b1;
    e.rd  = pins;
    e.req = req;
    q.push_back(e);
  endtask

  // Monitor: compares one cycle after each drive.
  always @(posedge clk) begin
    #1;
    if (!rst && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.req, "pin_oe",   32'(pin_oe),   32'(e.oe));
      chk(e.req, "pin_do",   32'(pin_do),   32'(e.dout));
      chk(e.req, "pin_rd",   32'(pin_rd),   32'(e.rd));
      chk(e.req, "sig_in",   32'(sig_in),   32'(e.sin));
      chk(e.req, "overflow", 32'(overflow), 32'(e.ovf));
    end
  end

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    pin_in = 24'hA5C3F0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "pin_oe",   32'(pin_oe),   32'h0);
    chk("R1", "pin_do",   32'(pin_do),   32'h0);
    chk("R1", "pin_rd",   32'(pin_rd),   32'h0);
    chk("R1", "sig_in",   32'(sig_in),   32'h7FFF);
    chk("R1", "overflow", 32'(overflow), 32'h0);
    @(negedge clk);
    rst = 1'b0;

    // R11 R7 R8 R10: all GPIO with mixed modes
    drive(4'h0, 4'h0, 24'h0, 24'hF0F00F, 24'h3C5A96, 24'h123456, 15'h7FFF, 15'h7FFF, "R11");
    // R3 R4 R9: clock out + serial port on pins 0..2
    drive(4'h5, 4'h0, 24'h0, 24'h0, 24'hFFFFFF, 24'h000004, 15'h0019, 15'h000B, "R3");
    // R3 R7: everything enabled, no skip
    drive(4'hF, 4'hF, 24'h0, 24'h0, 24'hAAAAAA, 24'h5A5A5A, 15'h2AAA, 15'h7FFF, "R3");
    // R5 R4: skipped pins keep GPIO
    drive(4'hF, 4'h3, 24'h000023, 24'h0, 24'h0000FF, 24'hFFF00F, 15'h7FFF, 15'h7FFF, "R5");
    // R6: only ten pins free
    drive(4'hF, 4'hF, 24'hFFFC00, 24'h0, 24'h0, 24'h0003FF, 15'h7FFF, 15'h7FFF, "R6");
    // R6: every pin skipped
    drive(4'h1, 4'h0, 24'hFFFFFF, 24'h0, 24'h123456, 24'hFFFFFF, 15'h7FFF, 15'h7FFF, "R6");
    // R8: open-drain on assigned pins
    drive(4'hF, 4'hF, 24'h0, 24'hFFFFFF, 24'h0F0F0F, 24'h0, 15'h5555, 15'h3FFF, "R8");
    // R9: counter-array and timers only
    drive(4'h0, 4'hE, 24'h000F00, 24'h0, 24'h0, 24'h00F0F0, 15'h0, 15'h0, "R9");
    // R2 R10: back-to-back random configuration and data changes
    for (int i = 0; i < 60; i++) begin
      logic [NP-1:0] sk;
      sk = (i % 3 == 0) ? 24'(($urandom | $urandom)) : 24'(($urandom & $urandom & $urandom));
      drive(4'($urandom), 4'($urandom), sk, 24'($urandom), 24'($urandom),
            24'($urandom), 15'($urandom), 15'($urandom), "R2");
    end
    repeat (3) @(posedge clk);
    #2;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule